// File: doc/BRIEF.md
# Flash Read Data Selector

This block forms the value returned for every read of a parallel NOR flash model. The command sequencer drives the current operating mode, and the selector picks the source for each read. The source can be the memory array, a fixed identification word, the live status byte, or one byte of the query ROM. Array reads cover one, two or four bytes. Multi-byte array reads are assembled in little-endian or big-endian order under a per-access select. The result is registered and appears one cycle after the read strobe.

The array sits outside the block. The block presents the read address on `arr_addr`, and the array answers in the same cycle on `arr_rdata` with four consecutive bytes. The byte at `arr_addr` is in bits 7:0 and the byte at `arr_addr+3` is in bits 31:24.

While a program or erase is busy, the block returns the status byte supplied by the sequencer, with one bit inverted by a local toggle flop. Software polls this byte and sees the bit change on each read. When the mode code is not valid, the block returns array data and raises a one-cycle request for the sequencer to drop back to read mode.

Top module: `fr_read_mux`

## Requirements
- R1: After reset, `rd_valid`, `rd_data` and `drop_mode` are 0. The status toggle is cleared, so the first status read after reset returns `status_in` unchanged.
- R2: `rd_valid` is 1 in the cycle after a cycle with `rd_en`=1, and 0 otherwise. `rd_data` changes only in the cycle after a strobe and keeps its value on idle cycles.
- R3: An array read uses `rd_width` 0 for one byte, 1 for two bytes, and 2 or 3 for four bytes. Bits above the bytes read are 0.
- R4: When `rd_be`=1, the lowest-addressed byte of a multi-byte array read sits in the most significant byte of the result. When `rd_be`=0, it sits in bits 7:0.
- R5: Mode codes are 0 read, 1 erase setup, 2 autoselect, 3 program busy, 4 chip erase busy, 5 sector erase busy, 6 query, and 7 invalid. Modes 0, 1 and 7 return array data. Mode 7 also sets `drop_mode` to 1 in the same cycle that `rd_valid` is 1.
- R6: In mode 2, offsets 0 and 1 return ID words 0 and 1, zero-extended. Offset 2 returns 0.
- R7: In mode 2, offsets 0x0E and 0x0F return ID words 2 and 3. If the selected word equals 0x00FF, array data is returned instead.
- R8: In mode 2, every other offset returns array data.
- R9: In modes 3, 4 and 5, a read returns {24'b0, `status_in` XOR (toggle<<6)}. Each such read then inverts the toggle.
- R10: The toggle keeps its value on idle cycles and on reads in any other mode.
- R11: In mode 6, an offset below `CFI_DEPTH` returns the matching parameter byte, zero-extended. A larger offset returns 0.
- R12: For ID and query lookups, the offset is `rd_addr[7:0]` shifted right by 0, 1 or 2 for `DEV_WIDTH` 1, 2 or 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe, one per access |
| rd_addr | input | ADDR_W | Byte address of the access |
| rd_width | input | 2 | Access size code |
| rd_be | input | 1 | 1 selects big-endian assembly |
| mode | input | 3 | Operating mode from the sequencer |
| status_in | input | 8 | Status byte held by the sequencer |
| arr_addr | output | ADDR_W | Address presented to the array |
| arr_rdata | input | 32 | Four array bytes starting at `arr_addr` |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 32 | Read result |
| drop_mode | output | 1 | Request to return to read mode |

## Verification
The array model returns bytes that differ at every address. This lets the array reads at each width and byte order expose any swapped, missing or extra lane. Autoselect reads walk the three fixed ID offsets, the two optional offsets (one configured as absent), an unrelated offset, and an address above bit 7. These reads separate the ID path, the array fallback and the offset truncation. Back-to-back status reads, status reads after idle gaps, and status reads after array reads distinguish toggling per read from toggling per cycle or per mode. Query reads at the last table entry and just past it locate the depth bound.

// File: rtl/fr_pkg.sv
package fr_pkg;

    typedef enum logic [2:0] {
        MD_READ     = 3'd0,
        MD_ERS_SET  = 3'd1,
        MD_AUTOSEL  = 3'd2,
        MD_PROG     = 3'd3,
        MD_ERS_CHIP = 3'd4,
        MD_ERS_SECT = 3'd5,
        MD_QUERY    = 3'd6,
        MD_INVALID  = 3'd7
    } fr_mode_e;

    typedef enum logic [1:0] {
        AW_BYTE = 2'd0,
        AW_HALF = 2'd1,
        AW_WORD = 2'd2,
        AW_WIDE = 2'd3
    } fr_width_e;

    localparam logic [15:0] ID_ABSENT = 16'h00FF;

    typedef struct packed {
        logic        valid;
        logic        drop;
        logic [31:0] data;
    } fr_resp_t;

    function automatic logic [2:0] aw_bytes(input logic [1:0] w);
        case (w)
            AW_BYTE: return 3'd1;
            AW_HALF: return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic is_busy_mode(input fr_mode_e m);
        return (m == MD_PROG) || (m == MD_ERS_CHIP) || (m == MD_ERS_SECT);
    endfunction

endpackage

// File: rtl/fr_lane_pack.sv
module fr_lane_pack
    import fr_pkg::*;
(
    input  logic [31:0] arr_bytes,
    input  logic [1:0]  width,
    input  logic        big_end,
    output logic [31:0] word
);
    localparam int LANES = 4;

    logic [2:0] nbytes;
    assign nbytes = aw_bytes(width);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic       in_use;
        logic [1:0] be_src;
        logic [7:0] le_b;
        logic [7:0] be_b;
        assign in_use = (3'(k) < nbytes);
        assign be_src = 2'(nbytes - 3'd1 - 3'(k));
        assign le_b   = arr_bytes[8*k +: 8];
        assign be_b   = arr_bytes[8*be_src +: 8];
        assign word[8*k +: 8] = !in_use ? 8'h00 : (big_end ? be_b : le_b);
    end

endmodule

// File: rtl/fr_id_query.sv
module fr_id_query
    import fr_pkg::*;
#(
    parameter logic [15:0] ID0 = 16'h0001,
    parameter logic [15:0] ID1 = 16'h0000,
    parameter logic [15:0] ID2 = ID_ABSENT,
    parameter logic [15:0] ID3 = ID_ABSENT,
    parameter int          CFI_DEPTH = 82,
    parameter logic [CFI_DEPTH*8-1:0] CFI_BYTES = '0
) (
    input  logic [7:0]  off,
    output logic        id_take,
    output logic [15:0] id_word,
    output logic [7:0]  q_byte
);
    localparam int IDX_W = $clog2(CFI_DEPTH * 8 + 1) + 1;

    always_comb begin
        id_take = 1'b0;
        id_word = 16'h0000;
        case (off)
            8'h00: begin id_take = 1'b1; id_word = ID0; end
            8'h01: begin id_take = 1'b1; id_word = ID1; end
            8'h02: begin id_take = 1'b1; id_word = 16'h0000; end
            8'h0E: begin id_take = (ID2 != ID_ABSENT); id_word = ID2; end
            8'h0F: begin id_take = (ID3 != ID_ABSENT); id_word = ID3; end
            default: ;
        endcase
    end

    logic             in_tab;
    logic [IDX_W-1:0] bit_idx;
    assign in_tab  = (32'(off) < CFI_DEPTH);
    assign bit_idx = in_tab ? IDX_W'({off, 3'b000}) : '0;
    assign q_byte  = in_tab ? CFI_BYTES[bit_idx +: 8] : 8'h00;

endmodule

// File: rtl/fr_status_tgl.sv
module fr_status_tgl (
    input  logic       clk,
    input  logic       rst,
    input  logic       rd_en,
    input  logic       is_busy,
    input  logic [7:0] status_in,
    output logic [7:0] stat_byte
);
    logic tgl_q;

    always_ff @(posedge clk) begin
        if (rst)                   tgl_q <= 1'b0;
        else if (rd_en && is_busy) tgl_q <= ~tgl_q;
    end

    assign stat_byte = status_in ^ {1'b0, tgl_q, 6'b000000};

    // R9: each status read inverts the reported bit
    a_r9_flip_per_read: assert property (@(posedge clk) disable iff (rst)
        (rd_en && is_busy) |=> (tgl_q != $past(tgl_q)));

    // R10: no change without a status read
    a_r10_hold_otherwise: assert property (@(posedge clk) disable iff (rst)
        !(rd_en && is_busy) |=> $stable(tgl_q));

endmodule

// File: rtl/fr_read_mux.sv
module fr_read_mux
    import fr_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter int          DEV_WIDTH = 2,
    parameter logic [15:0] ID0 = 16'h0001,
    parameter logic [15:0] ID1 = 16'h227E,
    parameter logic [15:0] ID2 = 16'h00FF,
    parameter logic [15:0] ID3 = 16'h2201,
    parameter int          CFI_DEPTH = 82,
    parameter logic [CFI_DEPTH*8-1:0] CFI_BYTES = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [1:0]        rd_width,
    input  logic              rd_be,
    input  logic [2:0]        mode,
    input  logic [7:0]        status_in,
    output logic [ADDR_W-1:0] arr_addr,
    input  logic [31:0]       arr_rdata,
    output logic              rd_valid,
    output logic [31:0]       rd_data,
    output logic              drop_mode
);
    localparam int OFF_SH = (DEV_WIDTH >= 4) ? 2 : ((DEV_WIDTH == 2) ? 1 : 0);

    fr_mode_e   mode_e;
    logic [7:0] off;
    logic [31:0] arr_word;
    logic        id_take;
    logic [15:0] id_word;
    logic [7:0]  q_byte;
    logic [7:0]  stat_byte;
    logic        busy;
    fr_resp_t    nxt, resp_q;

    assign mode_e   = fr_mode_e'(mode);
    assign busy     = is_busy_mode(mode_e);
    assign arr_addr = rd_addr;

    if (OFF_SH == 0) begin : g_off_byte
        assign off = rd_addr[7:0];
    end else begin : g_off_wide
        assign off = {{OFF_SH{1'b0}}, rd_addr[7:OFF_SH]};
    end

    fr_lane_pack u_pack (
        .arr_bytes (arr_rdata),
        .width     (rd_width),
        .big_end   (rd_be),
        .word      (arr_word)
    );

    fr_id_query #(
        .ID0(ID0), .ID1(ID1), .ID2(ID2), .ID3(ID3),
        .CFI_DEPTH(CFI_DEPTH), .CFI_BYTES(CFI_BYTES)
    ) u_idq (
        .off     (off),
        .id_take (id_take),
        .id_word (id_word),
        .q_byte  (q_byte)
    );

    fr_status_tgl u_stat (
        .clk       (clk),
        .rst       (rst),
        .rd_en     (rd_en),
        .is_busy   (busy),
        .status_in (status_in),
        .stat_byte (stat_byte)
    );

    always_comb begin
        nxt.valid = rd_en;
        nxt.drop  = rd_en && (mode_e == MD_INVALID);
        case (mode_e)
            MD_AUTOSEL:  nxt.data = id_take ? {16'h0000, id_word} : arr_word;
            MD_PROG,
            MD_ERS_CHIP,
            MD_ERS_SECT: nxt.data = {24'h000000, stat_byte};
            MD_QUERY:    nxt.data = {24'h000000, q_byte};
            default:     nxt.data = arr_word;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_q <= '0;
        end else begin
            resp_q.valid <= nxt.valid;
            resp_q.drop  <= nxt.drop;
            if (rd_en) resp_q.data <= nxt.data;
        end
    end

    assign rd_valid  = resp_q.valid;
    assign rd_data   = resp_q.data;
    assign drop_mode = resp_q.drop;

    // R2: one result per strobe, one cycle later
    a_r2_valid_after_strobe: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);
    a_r2_quiet_when_idle: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> (!rd_valid && $stable(rd_data)));
    // R5: drop request only accompanies a result
    a_r5_drop_with_valid: assert property (@(posedge clk) disable iff (rst)
        drop_mode |-> rd_valid);
    // R3: single-byte array reads leave upper bits clear
    a_r3_byte_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_width == 2'd0 && mode == 3'd0) |=> (rd_data[31:8] == 24'h0));

endmodule

// File: tb/test_fr_read_mux.sv
module test_fr_read_mux;

    localparam int DEPTH = 82;

    function automatic logic [DEPTH*8-1:0] mk_table();
        logic [DEPTH*8-1:0] v;
        for (int i = 0; i < DEPTH; i++) v[i*8 +: 8] = 8'(8'h40 + i);
        return v;
    endfunction
    localparam logic [DEPTH*8-1:0] TAB = mk_table();

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_en = 1'b0;
    logic [15:0] rd_addr = '0;
    logic [1:0]  rd_width = '0;
    logic        rd_be = 1'b0;
    logic [2:0]  mode = '0;
    logic [7:0]  status_in = '0;
    logic [15:0] arr_addr;
    logic [31:0] arr_rdata;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        drop_mode;

    always #2.5 clk = ~clk;

    fr_read_mux #(
        .ADDR_W(16), .DEV_WIDTH(2),
        .ID0(16'h0001), .ID1(16'h227E), .ID2(16'h00FF), .ID3(16'h2201),
        .CFI_DEPTH(DEPTH), .CFI_BYTES(TAB)
    ) i_fr_read_mux (
        .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_width(rd_width), .rd_be(rd_be), .mode(mode), .status_in(status_in),
        .arr_addr(arr_addr), .arr_rdata(arr_rdata), .rd_valid(rd_valid),
        .rd_data(rd_data), .drop_mode(drop_mode)
    );

    function automatic logic [7:0] mem_b(input logic [15:0] a);
        return 8'(a[7:0] * 8'd29 + a[15:8] + 8'd11);
    endfunction

    always_comb begin
        for (int i = 0; i < 4; i++) arr_rdata[i*8 +: 8] = mem_b(16'(arr_addr + 16'(i)));
    end

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;
    bit tgl_m = 0;
    logic        e_valid = 0;
    logic [31:0] e_data = 0;
    logic        e_drop = 0;
    string       e_tag = "R1";

    function automatic logic [31:0] arr_ref(input logic [15:0] a, input logic [1:0] w, input logic be);
        int n;
        logic [31:0] v;
        n = (w == 0) ? 1 : ((w == 1) ? 2 : 4);
        v = 0;
        for (int i = 0; i < n; i++) begin
            if (be) v = (v << 8) | 32'(mem_b(16'(a + 16'(i))));
            else    v = v | (32'(mem_b(16'(a + 16'(i)))) << (8 * i));
        end
        return v;
    endfunction

    task automatic check_now();
        n_checks++;
        if (rd_valid !== e_valid || rd_data !== e_data || drop_mode !== e_drop) begin
            n_fail++;
            $display("FAIL %s: valid/data/drop actual %b/%h/%b expected %b/%h/%b",
                     e_tag, rd_valid, rd_data, drop_mode, e_valid, e_data, e_drop);
        end
    endtask

    // one clock: compare previous expectation, then drive and predict
    task automatic step(input bit en, input logic [2:0] m, input logic [15:0] a,
                        input logic [1:0] w, input bit be, input logic [7:0] st, input string tag);
        logic [7:0] off;
        @(negedge clk);
        check_now();
        rd_en = en; mode = m; rd_addr = a; rd_width = w; rd_be = be; status_in = st;
        e_tag = tag;
        e_valid = en;
        e_drop = en && (m == 3'd7);
        off = {1'b0, a[7:1]};
        if (en) begin
            case (m)
                3'd2: begin
                    if (off == 0)      e_data = 32'h0001;
                    else if (off == 1) e_data = 32'h227E;
                    else if (off == 2) e_data = 0;
                    else if (off == 8'h0F) e_data = 32'h2201;
                    else e_data = arr_ref(a, w, be);
                end
                3'd3, 3'd4, 3'd5: begin
                    e_data = {24'h0, st ^ (tgl_m ? 8'h40 : 8'h00)};
                    tgl_m = ~tgl_m;
                end
                3'd6: e_data = (int'(off) < DEPTH) ? 32'(8'h40 + off) : 0;
                default: e_data = arr_ref(a, w, be);
            endcase
        end
    endtask

    task automatic idle(input string tag);
        step(0, 3'd0, 16'h0, 2'd0, 0, 8'h00, tag);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1: reset state, then first status read returns status unmodified
        idle("R1");
        step(1, 3'd3, 16'h0, 2'd0, 0, 8'h80, "R1");
        idle("R2");
        idle("R2");
        // R9: consecutive status reads alternate bit 6
        step(1, 3'd4, 16'h0, 2'd0, 0, 8'h80, "R9");
        step(1, 3'd5, 16'h0, 2'd0, 0, 8'h00, "R9");
        step(1, 3'd3, 16'h0, 2'd0, 0, 8'h08, "R9");
        // R10: idle cycles do not toggle
        idle("R10"); idle("R10"); idle("R10");
        step(1, 3'd3, 16'h0, 2'd0, 0, 8'h80, "R10");
        // R3/R4: array reads, every width and byte order
        step(1, 3'd0, 16'h0013, 2'd0, 0, 8'h00, "R3");
        step(1, 3'd0, 16'h0020, 2'd1, 0, 8'h00, "R3");
        step(1, 3'd0, 16'h0020, 2'd1, 1, 8'h00, "R4");
        step(1, 3'd0, 16'h0144, 2'd2, 0, 8'h00, "R3");
        step(1, 3'd0, 16'h0144, 2'd2, 1, 8'h00, "R4");
        step(1, 3'd0, 16'h0250, 2'd3, 1, 8'h00, "R3");
        idle("R2");
        // R10: non-status reads leave toggle alone
        step(1, 3'd3, 16'h0, 2'd0, 0, 8'h80, "R10");
        // R5: erase setup and invalid mode return array data
        step(1, 3'd1, 16'h0031, 2'd2, 1, 8'h00, "R5");
        step(1, 3'd7, 16'h0062, 2'd1, 0, 8'h00, "R5");
        idle("R5");
        // R6/R7/R8/R12: autoselect
        step(1, 3'd2, 16'h0000, 2'd1, 0, 8'h00, "R6");
        step(1, 3'd2, 16'h0002, 2'd1, 0, 8'h00, "R6");
        step(1, 3'd2, 16'h0004, 2'd1, 0, 8'h00, "R6");
        step(1, 3'd2, 16'h001C, 2'd1, 1, 8'h00, "R7");
        step(1, 3'd2, 16'h001E, 2'd1, 0, 8'h00, "R7");
        step(1, 3'd2, 16'h0010, 2'd2, 0, 8'h00, "R8");
        step(1, 3'd2, 16'h0302, 2'd1, 0, 8'h00, "R12");
        step(1, 3'd2, 16'h0003, 2'd1, 0, 8'h00, "R12");
        // R11: query table bounds
        step(1, 3'd6, 16'h0020, 2'd0, 0, 8'h00, "R11");
        step(1, 3'd6, 16'h00A2, 2'd0, 0, 8'h00, "R11");
        step(1, 3'd6, 16'h00A4, 2'd0, 0, 8'h00, "R11");
        step(1, 3'd6, 16'h01FE, 2'd0, 0, 8'h00, "R11");
        step(1, 3'd3, 16'h0, 2'd0, 0, 8'h80, "R10");
        idle("R2");
        idle("R2");
        @(negedge clk);
        check_now();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule